// File: doc/BRIEF.md
# Three-Level Page Table Walker

The block translates a 32-bit virtual address into a 36-bit physical address by walking page tables held in memory. A request carries the virtual address, the access kind (load, store or instruction fetch), a user/supervisor flag and a bypass flag. For a translated request the walker first reads a context-table word selected by a root-pointer register and a context number. It then follows pointer entries through up to three table levels, and it stops at the first page entry it meets. A page entry can map a 16 MB, 256 KB or 4 KB page. Any malformed or missing entry ends the walk with a fault code that records the level where it stopped.

The permission decision is not made here. When a page entry is found, the walker shows the entry's access code, the access kind and the user flag to an external checker and waits one cycle for its verdict. If the checker allows the access, the walker sets the referenced bit and, on a store, the modified bit. It writes the entry back to its table address only when that changes the word. In bypass mode the address passes through with full rights. The one exception is an instruction fetch while boot mode is set: it is redirected into a ROM window and gets read and execute rights only.

The walker handles one request at a time and raises `busy_o` while it works. It drives a single memory port. A request on that port is held until it is granted, and each read returns its data with a response strobe and a bus-error flag.

Top module: `pt_walker`

## Requirements
- R1: The first read of a translated request goes to address (root_ptr_i << 4) + (ctx_num_i * 4).
- R2: The entry type is the low two bits of every fetched word: 0 invalid, 1 pointer, 2 page entry, 3 reserved. A pointer gives the next table base as (word with bits [1:0] cleared) << 4. The table indices are VA[31:24]*4 at level 1, VA[23:18]*4 at level 2 and VA[17:12]*4 at level 3. The context table is level 0.
- R3: A page entry at level 1 maps 16 MB (page_size_o=2) with offset VA[23:0]. At level 2 it maps 256 KB (page_size_o=1) with offset VA[17:0]. At level 3 it maps 4 KB (page_size_o=0) with offset VA[11:0]. The physical address is (entry[31:8] << 12) + offset, and pte_o returns the final entry.
- R4: An invalid entry ends the walk with fault_o=1 and fault_code_o = (level << 8) | (1 << 2).
- R5: A translation error gives fault_code_o = (level << 8) | (4 << 2). Four cases count as translation errors: a reserved entry, a bus error on a read, a page entry in the context table, and a pointer entry at level 3.
- R6: If chk_ok_i is low while chk_valid_o is high, the walk ends with perm_denied_o=1, fault_o=0, and no write to memory.
- R7: An allowed access sets the referenced bit (entry bit 5). A store also sets the modified bit (entry bit 6). The entry is written back to the address it was read from only when its value changed.
- R8: With req_bypass_i set, paddr_o is the virtual address zero-extended and rights_o is 3'b111 ({read, write, execute}). No memory access takes place, and done_o follows one cycle after acceptance. rights_o is 0 for translated requests.
- R9: A bypass instruction fetch (req_kind_i=2) while boot_mode_i is set gives paddr_o = rom_base_i | VA[18:0] and rights_o = 3'b101. Loads and stores in boot mode still pass through unchanged.
- R10: busy_o is high from acceptance until done_o, and requests offered while busy are ignored. A memory request keeps its address and direction until mem_gnt_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request, taken when busy_o is low |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | 0 load, 1 store, 2 instruction fetch |
| req_user_i | input | 1 | User-mode access |
| req_bypass_i | input | 1 | Physical (untranslated) access |
| root_ptr_i | input | 32 | Context table pointer, in 16-byte units |
| ctx_num_i | input | 8 | Context number |
| boot_mode_i | input | 1 | Redirect bypass fetches to ROM |
| rom_base_i | input | 36 | ROM window base |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle result strobe |
| fault_o | output | 1 | Walk ended in a fault |
| fault_code_o | output | 10 | Level in [9:8], fault type in [4:2] |
| perm_denied_o | output | 1 | Checker refused the access |
| paddr_o | output | 36 | Physical address |
| page_size_o | output | 2 | 0 4 KB, 1 256 KB, 2 16 MB |
| pte_o | output | 32 | Final entry as stored after any update |
| rights_o | output | 3 | Bypass rights {read, write, execute} |
| chk_valid_o | output | 1 | Permission query valid |
| chk_acc_o | output | 3 | Entry access code, bits [4:2] |
| chk_kind_o | output | 2 | Access kind of the query |
| chk_user_o | output | 1 | User flag of the query |
| chk_ok_i | input | 1 | Checker verdict, same cycle |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Write (1) or read (0) |
| mem_addr_o | output | 36 | Memory byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| mem_err_i | input | 1 | Bus error on the read |

## Verification
The walk is run against tables that end at each of the three levels, and the read count tells a real descent apart from a shortcut. Fault cases cover an invalid word at every level and each of the four translation-error causes, so a wrong level tag or a wrong type shows up in the code. Repeated loads, stores and fetches to one 4 KB page check that the write-back happens only on the first referencing access and on the first store. A denied access leaves memory untouched. Bypass requests are tried with boot mode on and off and with fetch and load kinds. A walk under a grant that stalls every other cycle, with a competing request held during the walk, shows that requests are held on the memory port and that a busy walker ignores new requests.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int VA_W  = 32;
  localparam int PTE_W = 32;
  localparam int FC_W  = 10;
  localparam int PTE_M_BIT = 6;
  localparam int PTE_R_BIT = 5;

  localparam logic [1:0] KIND_LOAD  = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_XLATE   = 3'd4;

  typedef enum logic [1:0] {ET_INV = 2'd0, ET_PTD = 2'd1, ET_PTE = 2'd2, ET_RSV = 2'd3} ent_type_e;
  typedef enum logic [1:0] {EV_NEXT, EV_LEAF, EV_FAULT} ev_act_e;
endpackage

// File: rtl/pt_walk_addr.sv
module pt_walk_addr #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic [1:0]       level_i,
  input  logic [19:0]      vpn_i,
  input  logic [31:0]      root_ptr_i,
  input  logic [CTX_W-1:0] ctx_i,
  input  logic [PA_W-1:0]  base_i,
  output logic [PA_W-1:0]  addr_o
);
  always_comb begin
    case (level_i)
      2'd0:    addr_o = PA_W'({root_ptr_i, 4'b0}) + PA_W'({ctx_i, 2'b00});
      2'd1:    addr_o = base_i + PA_W'({vpn_i[19:12], 2'b00});
      2'd2:    addr_o = base_i + PA_W'({vpn_i[11:6], 2'b00});
      default: addr_o = base_i + PA_W'({vpn_i[5:0], 2'b00});
    endcase
  end
endmodule

// File: rtl/pt_entry_eval.sv
module pt_entry_eval
  import pt_walker_pkg::*;
(
  input  logic [1:0]      level_i,
  input  logic [1:0]      etype_i,
  input  logic            bus_err_i,
  output ev_act_e         act_o,
  output logic [FC_W-1:0] code_o,
  output logic [1:0]      size_o
);
  logic [2:0] ftype;
  always_comb begin
    act_o  = EV_FAULT;
    ftype  = FT_XLATE;
    size_o = SZ_4K;
    if (!bus_err_i) begin
      case (ent_type_e'(etype_i))
        ET_INV: ftype = FT_INVALID;
        ET_PTD: if (level_i != 2'd3) act_o = EV_NEXT;
        ET_PTE: if (level_i != 2'd0) act_o = EV_LEAF;
        default: ftype = FT_XLATE;
      endcase
    end
    case (level_i)
      2'd1:    size_o = SZ_16M;
      2'd2:    size_o = SZ_256K;
      default: size_o = SZ_4K;
    endcase
    code_o = {level_i, 3'b000, ftype, 2'b00};
  end
endmodule

// File: rtl/pt_leaf_map.sv
module pt_leaf_map
  import pt_walker_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [23:0]      va_low_i,
  input  logic [1:0]       size_i,
  input  logic             is_store_i,
  output logic [PA_W-1:0]  paddr_o,
  output logic [PTE_W-1:0] upd_pte_o,
  output logic             need_wb_o
);
  logic [23:0] offset;
  always_comb begin
    case (size_i)
      SZ_16M:  offset = va_low_i;
      SZ_256K: offset = {6'b0, va_low_i[17:0]};
      default: offset = {12'b0, va_low_i[11:0]};
    endcase
    paddr_o = PA_W'({pte_i[31:8], 12'b0}) + PA_W'(offset);
    upd_pte_o = pte_i;
    upd_pte_o[PTE_R_BIT] = 1'b1;
    if (is_store_i) upd_pte_o[PTE_M_BIT] = 1'b1;
    need_wb_o = (upd_pte_o != pte_i);
  end
endmodule

// File: rtl/pt_bypass.sv
module pt_bypass
  import pt_walker_pkg::*;
#(
  parameter int PA_W      = 36,
  parameter int ROM_OFF_W = 19
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      kind_i,
  input  logic            boot_i,
  input  logic [PA_W-1:0] rom_base_i,
  output logic [PA_W-1:0] paddr_o,
  output logic [2:0]      rights_o
);
  always_comb begin
    if (boot_i && kind_i == KIND_FETCH) begin
      paddr_o  = rom_base_i | PA_W'(va_i[ROM_OFF_W-1:0]);
      rights_o = 3'b101;
    end else begin
      paddr_o  = PA_W'(va_i);
      rights_o = 3'b111;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [31:0]      req_vaddr_i,
  input  logic [1:0]       req_kind_i,
  input  logic             req_user_i,
  input  logic             req_bypass_i,
  input  logic [31:0]      root_ptr_i,
  input  logic [CTX_W-1:0] ctx_num_i,
  input  logic             boot_mode_i,
  input  logic [PA_W-1:0]  rom_base_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fault_o,
  output logic [9:0]       fault_code_o,
  output logic             perm_denied_o,
  output logic [PA_W-1:0]  paddr_o,
  output logic [1:0]       page_size_o,
  output logic [31:0]      pte_o,
  output logic [2:0]       rights_o,
  output logic             chk_valid_o,
  output logic [2:0]       chk_acc_o,
  output logic [1:0]       chk_kind_o,
  output logic             chk_user_o,
  input  logic             chk_ok_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [PA_W-1:0]  mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic             mem_err_i
);
  typedef enum logic [2:0] {ST_IDLE, ST_RD_REQ, ST_RD_WAIT, ST_CHECK, ST_WR_REQ} st_e;

  st_e               state_q, state_d;
  logic [1:0]        level_q, level_d;
  logic [VA_W-1:0]   va_q, va_d;
  logic [1:0]        kind_q, kind_d;
  logic              user_q, user_d;
  logic [PA_W-1:0]   base_q, base_d;
  logic [PA_W-1:0]   wb_addr_q, wb_addr_d;
  logic [PTE_W-1:0]  pte_q, pte_d;
  logic [1:0]        size_q, size_d;

  logic [PA_W-1:0]   walk_addr;
  ev_act_e           ev_act;
  logic [FC_W-1:0]   ev_code;
  logic [1:0]        ev_size;
  logic [PA_W-1:0]   leaf_paddr;
  logic [PTE_W-1:0]  upd_pte;
  logic              need_wb;
  logic [PA_W-1:0]   byp_paddr;
  logic [2:0]        byp_rights;

  logic              fin, fin_fault, fin_perm;
  logic [FC_W-1:0]   fin_code;
  logic [PA_W-1:0]   fin_paddr;
  logic [1:0]        fin_size;
  logic [PTE_W-1:0]  fin_pte;
  logic [2:0]        fin_rights;

  pt_walk_addr #(.PA_W(PA_W), .CTX_W(CTX_W)) u_addr (
    .level_i    (level_q),
    .vpn_i      (va_q[31:12]),
    .root_ptr_i (root_ptr_i),
    .ctx_i      (ctx_num_i),
    .base_i     (base_q),
    .addr_o     (walk_addr)
  );

  pt_entry_eval u_eval (
    .level_i   (level_q),
    .etype_i   (mem_rdata_i[1:0]),
    .bus_err_i (mem_err_i),
    .act_o     (ev_act),
    .code_o    (ev_code),
    .size_o    (ev_size)
  );

  pt_leaf_map #(.PA_W(PA_W)) u_leaf (
    .pte_i      (pte_q),
    .va_low_i   (va_q[23:0]),
    .size_i     (size_q),
    .is_store_i (kind_q == KIND_STORE),
    .paddr_o    (leaf_paddr),
    .upd_pte_o  (upd_pte),
    .need_wb_o  (need_wb)
  );

  pt_bypass #(.PA_W(PA_W)) u_byp (
    .va_i       (req_vaddr_i),
    .kind_i     (req_kind_i),
    .boot_i     (boot_mode_i),
    .rom_base_i (rom_base_i),
    .paddr_o    (byp_paddr),
    .rights_o   (byp_rights)
  );

  always_comb begin
    state_d   = state_q;
    level_d   = level_q;
    va_d      = va_q;
    kind_d    = kind_q;
    user_d    = user_q;
    base_d    = base_q;
    wb_addr_d = wb_addr_q;
    pte_d     = pte_q;
    size_d    = size_q;
    fin        = 1'b0;
    fin_fault  = 1'b0;
    fin_perm   = 1'b0;
    fin_code   = '0;
    fin_paddr  = '0;
    fin_size   = SZ_4K;
    fin_pte    = '0;
    fin_rights = '0;
    case (state_q)
      ST_IDLE: if (req_valid_i) begin
        va_d   = req_vaddr_i;
        kind_d = req_kind_i;
        user_d = req_user_i;
        if (req_bypass_i) begin
          fin        = 1'b1;
          fin_paddr  = byp_paddr;
          fin_rights = byp_rights;
        end else begin
          level_d = 2'd0;
          state_d = ST_RD_REQ;
        end
      end
      ST_RD_REQ: if (mem_gnt_i) begin
        wb_addr_d = walk_addr;
        state_d   = ST_RD_WAIT;
      end
      ST_RD_WAIT: if (mem_rvalid_i) begin
        case (ev_act)
          EV_NEXT: begin
            base_d  = {mem_rdata_i[31:2], 6'b0};
            level_d = level_q + 2'd1;
            state_d = ST_RD_REQ;
          end
          EV_LEAF: begin
            pte_d   = mem_rdata_i;
            size_d  = ev_size;
            state_d = ST_CHECK;
          end
          default: begin
            fin       = 1'b1;
            fin_fault = 1'b1;
            fin_code  = ev_code;
            fin_pte   = mem_rdata_i;
            state_d   = ST_IDLE;
          end
        endcase
      end
      ST_CHECK: begin
        if (!chk_ok_i) begin
          fin      = 1'b1;
          fin_perm = 1'b1;
          fin_pte  = pte_q;
          state_d  = ST_IDLE;
        end else if (need_wb) begin
          pte_d   = upd_pte;
          state_d = ST_WR_REQ;
        end else begin
          fin       = 1'b1;
          fin_paddr = leaf_paddr;
          fin_size  = size_q;
          fin_pte   = pte_q;
          state_d   = ST_IDLE;
        end
      end
      ST_WR_REQ: if (mem_gnt_i) begin
        fin       = 1'b1;
        fin_paddr = leaf_paddr;
        fin_size  = size_q;
        fin_pte   = pte_q;
        state_d   = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      level_q   <= '0;
      va_q      <= '0;
      kind_q    <= '0;
      user_q    <= 1'b0;
      base_q    <= '0;
      wb_addr_q <= '0;
      pte_q     <= '0;
      size_q    <= '0;
    end else begin
      state_q   <= state_d;
      level_q   <= level_d;
      va_q      <= va_d;
      kind_q    <= kind_d;
      user_q    <= user_d;
      base_q    <= base_d;
      wb_addr_q <= wb_addr_d;
      pte_q     <= pte_d;
      size_q    <= size_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o        <= 1'b0;
      fault_o       <= 1'b0;
      fault_code_o  <= '0;
      perm_denied_o <= 1'b0;
      paddr_o       <= '0;
      page_size_o   <= '0;
      pte_o         <= '0;
      rights_o      <= '0;
    end else begin
      done_o <= fin;
      if (fin) begin
        fault_o       <= fin_fault;
        fault_code_o  <= fin_code;
        perm_denied_o <= fin_perm;
        paddr_o       <= fin_paddr;
        page_size_o   <= fin_size;
        pte_o         <= fin_pte;
        rights_o      <= fin_rights;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign chk_valid_o = (state_q == ST_CHECK);
  assign chk_acc_o   = pte_q[4:2];
  assign chk_kind_o  = kind_q;
  assign chk_user_o  = user_q;
  assign mem_req_o   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign mem_we_o    = (state_q == ST_WR_REQ);
  assign mem_addr_o  = (state_q == ST_WR_REQ) ? wb_addr_q : walk_addr;
  assign mem_wdata_o = pte_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W  = 36,
  parameter int CTX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_bypass_i,
  input logic [31:0]      root_ptr_i,
  input logic [CTX_W-1:0] ctx_num_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             fault_o,
  input logic [9:0]       fault_code_o,
  input logic             perm_denied_o,
  input logic [1:0]       page_size_o,
  input logic             chk_valid_o,
  input logic             chk_ok_i,
  input logic             mem_req_o,
  input logic             mem_we_o,
  input logic [PA_W-1:0]  mem_addr_o,
  input logic [31:0]      mem_wdata_o,
  input logic             mem_gnt_i
);
  logic [PA_W-1:0] exp_ctx_addr;
  logic            accept;
  assign exp_ctx_addr = (PA_W'(root_ptr_i) << 4) + (PA_W'(ctx_num_i) * 4);
  assign accept = req_valid_i && !busy_o;

  a_r1_ctx_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !req_bypass_i) |=> (mem_req_o && !mem_we_o && mem_addr_o == $past(exp_ctx_addr)));

  a_r3_size_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o) |-> (page_size_o != 2'd3));

  a_r4_code_form: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> ((fault_code_o[4:2] == 3'd1 || fault_code_o[4:2] == 3'd4)
                             && fault_code_o[7:5] == 3'd0 && fault_code_o[1:0] == 2'd0));

  a_r6_denied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_valid_o && !chk_ok_i) |=> (done_o && perm_denied_o && !fault_o && !mem_req_o));

  a_r7_wb_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[5]);

  a_r8_bypass_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_bypass_i) |=> (done_o && !fault_o && !busy_o));

  a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W), .CTX_W(CTX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .req_bypass_i  (req_bypass_i),
  .root_ptr_i    (root_ptr_i),
  .ctx_num_i     (ctx_num_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .fault_o       (fault_o),
  .fault_code_o  (fault_code_o),
  .perm_denied_o (perm_denied_o),
  .page_size_o   (page_size_o),
  .chk_valid_o   (chk_valid_o),
  .chk_ok_i      (chk_ok_i),
  .mem_req_o     (mem_req_o),
  .mem_we_o      (mem_we_o),
  .mem_addr_o    (mem_addr_o),
  .mem_wdata_o   (mem_wdata_o),
  .mem_gnt_i     (mem_gnt_i)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 0, req_user = 0, req_bypass = 0, boot_mode = 0;
  logic [31:0] req_vaddr = 0;
  logic [1:0]  req_kind = 0;
  logic [31:0] root_ptr = 32'h100;
  logic [7:0]  ctx_num = 8'd3;
  logic [35:0] rom_base = 36'hF_FFF0_0000;
  logic        busy, done, fault, perm_denied, chk_valid, chk_user;
  logic [9:0]  fault_code;
  logic [35:0] paddr, mem_addr;
  logic [1:0]  page_size, chk_kind;
  logic [31:0] pte, mem_wdata;
  logic [2:0]  rights, chk_acc;
  logic        chk_ok = 1;
  logic        mem_req, mem_we, mem_gnt;
  logic        mem_rvalid = 0, mem_err = 0;
  logic [31:0] mem_rdata = 0;

  pt_walker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vaddr_i(req_vaddr), .req_kind_i(req_kind),
    .req_user_i(req_user), .req_bypass_i(req_bypass),
    .root_ptr_i(root_ptr), .ctx_num_i(ctx_num), .boot_mode_i(boot_mode), .rom_base_i(rom_base),
    .busy_o(busy), .done_o(done), .fault_o(fault), .fault_code_o(fault_code),
    .perm_denied_o(perm_denied), .paddr_o(paddr), .page_size_o(page_size), .pte_o(pte),
    .rights_o(rights), .chk_valid_o(chk_valid), .chk_acc_o(chk_acc), .chk_kind_o(chk_kind),
    .chk_user_o(chk_user), .chk_ok_i(chk_ok),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_gnt_i(mem_gnt), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err)
  );

  // memory model
  logic [31:0] mem [logic [35:0]];
  bit          errmap [logic [35:0]];
  logic        stall = 0, gnt_tog = 0;
  int          rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [35:0] last_wr_addr = 0;
  assign mem_gnt = !stall || gnt_tog;

  always @(posedge clk) begin
    gnt_tog <= ~gnt_tog;
    mem_rvalid <= 1'b0;
    if (done) done_cnt++;
    if (mem_req && mem_gnt) begin
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        wr_cnt++;
        last_wr_addr = mem_addr;
      end else begin
        rd_cnt++;
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
        mem_err    <= errmap.exists(mem_addr);
      end
    end
  end

  int checks = 0, errors = 0;
  logic        r_fault, r_perm;
  logic [9:0]  r_code;
  logic [35:0] r_paddr;
  logic [1:0]  r_size;
  logic [31:0] r_pte;
  logic [2:0]  r_rights;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_pte(input logic [23:0] ppn, input bit m, input bit r, input logic [2:0] acc);
    return {ppn, 1'b0, m, r, acc, 2'b10};
  endfunction

  task automatic run(input logic [31:0] va, input logic [1:0] kind, input bit byp);
    int n = 0;
    @(negedge clk);
    req_vaddr = va; req_kind = kind; req_bypass = byp; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    if (!done) check(0, "watchdog", 0, 1);
    r_fault = fault; r_perm = perm_denied; r_code = fault_code; r_paddr = paddr;
    r_size = page_size; r_pte = pte; r_rights = rights;
  endtask

  localparam logic [31:0] VA_A = {8'h0A, 6'd5, 6'd7, 12'h123};
  localparam logic [31:0] VA_B = {8'h0B, 24'hABC456};
  localparam logic [31:0] VA_C = {8'h0C, 6'd9, 18'h21234};

  task automatic t_reset;
    check(!busy && !done && !mem_req, "R10 reset idle", {busy, done, mem_req}, 0);
  endtask

  task automatic t_walk_4k;
    int r0 = rd_cnt, w0 = wr_cnt;
    run(VA_A, 2'd0, 0);
    check(!r_fault && !r_perm, "R3 4k no fault", {r_fault, r_perm}, 0);
    check(r_paddr == 36'h12345123, "R3 4k paddr", r_paddr, 36'h12345123);
    check(r_size == 2'd0, "R3 4k size", r_size, 0);
    check(rd_cnt - r0 == 4, "R2 4k read count", rd_cnt - r0, 4);
    check(wr_cnt - w0 == 1 && last_wr_addr == 36'h401C, "R7 load wb addr", last_wr_addr, 36'h401C);
    check(mem[36'h401C] == mk_pte(24'h12345, 0, 1, 3'd3), "R7 ref set", mem[36'h401C], mk_pte(24'h12345, 0, 1, 3'd3));
    check(r_pte == mk_pte(24'h12345, 0, 1, 3'd3), "R3 pte out", r_pte, mk_pte(24'h12345, 0, 1, 3'd3));
    check(r_rights == 3'd0, "R8 walk rights zero", r_rights, 0);
  endtask

  task automatic t_wb_rules;
    int w0 = wr_cnt;
    run(VA_A, 2'd0, 0);
    check(wr_cnt == w0, "R7 load no change no wb", wr_cnt - w0, 0);
    run(VA_A, 2'd1, 0);
    check(wr_cnt == w0 + 1, "R7 store wb", wr_cnt - w0, 1);
    check(mem[36'h401C] == mk_pte(24'h12345, 1, 1, 3'd3), "R7 mod set", mem[36'h401C], mk_pte(24'h12345, 1, 1, 3'd3));
    run(VA_A, 2'd1, 0);
    check(wr_cnt == w0 + 1, "R7 store already mod", wr_cnt - w0, 1);
    run(VA_A, 2'd2, 0);
    check(wr_cnt == w0 + 1 && !r_fault && r_paddr == 36'h12345123, "R7 fetch no wb", wr_cnt - w0, 1);
  endtask

  task automatic t_large_pages;
    int r0 = rd_cnt;
    run(VA_B, 2'd0, 0);
    check(r_paddr == 36'h500000 + 36'hABC456 && r_size == 2'd2, "R3 16M map", r_paddr, 36'hFBC456);
    check(rd_cnt - r0 == 2, "R2 16M read count", rd_cnt - r0, 2);
    r0 = rd_cnt;
    run(VA_C, 2'd0, 0);
    check(r_paddr == 36'h700000 + 36'h21234 && r_size == 2'd1, "R3 256K map", r_paddr, 36'h721234);
    check(rd_cnt - r0 == 3, "R2 256K read count", rd_cnt - r0, 3);
  endtask

  task automatic t_invalid;
    run({8'h0F, 24'h0}, 2'd0, 0);
    check(r_fault && r_code == 10'h104, "R4 invalid L1", r_code, 10'h104);
    run({8'h0D, 24'h0}, 2'd0, 0);
    check(r_fault && r_code == 10'h204, "R4 invalid L2", r_code, 10'h204);
    run({8'h0A, 6'd5, 6'd11, 12'h0}, 2'd0, 0);
    check(r_fault && r_code == 10'h304, "R4 invalid L3", r_code, 10'h304);
    ctx_num = 8'd5;
    run(VA_A, 2'd0, 0);
    check(r_fault && r_code == 10'h004, "R4 invalid ctx", r_code, 10'h004);
    ctx_num = 8'd3;
  endtask

  task automatic t_xlate_err;
    run({8'h0E, 24'h0}, 2'd0, 0);
    check(r_fault && r_code == 10'h110, "R5 reserved L1", r_code, 10'h110);
    run({8'h0A, 6'd5, 6'd8, 12'h0}, 2'd0, 0);
    check(r_fault && r_code == 10'h310, "R5 bus err L3", r_code, 10'h310);
    run({8'h0A, 6'd5, 6'd9, 12'h0}, 2'd0, 0);
    check(r_fault && r_code == 10'h310, "R5 pointer at L3", r_code, 10'h310);
    ctx_num = 8'd4;
    run(VA_A, 2'd0, 0);
    check(r_fault && r_code == 10'h010, "R5 pte in ctx", r_code, 10'h010);
    ctx_num = 8'd6;
    run(VA_A, 2'd0, 0);
    check(r_fault && r_code == 10'h010, "R5 bus err ctx", r_code, 10'h010);
    ctx_num = 8'd3;
  endtask

  task automatic t_perm;
    int w0 = wr_cnt;
    chk_ok = 0;
    run({8'h0A, 6'd5, 6'd10, 12'h0}, 2'd1, 0);
    chk_ok = 1;
    check(r_perm && !r_fault, "R6 denied flag", {r_perm, r_fault}, 2'b10);
    check(wr_cnt == w0 && mem[36'h4028] == mk_pte(24'h0AAAA, 0, 0, 3'd1), "R6 no wb", mem[36'h4028], mk_pte(24'h0AAAA, 0, 0, 3'd1));
  endtask

  task automatic t_bypass;
    int r0 = rd_cnt;
    boot_mode = 0;
    run(32'h89ABCDEF, 2'd0, 1);
    check(r_paddr == 36'h0_89ABCDEF && r_rights == 3'b111, "R8 bypass load", r_paddr, 36'h089ABCDEF);
    run(32'h12345678, 2'd2, 1);
    check(r_paddr == 36'h012345678 && r_rights == 3'b111, "R8 bypass fetch no boot", r_paddr, 36'h012345678);
    check(rd_cnt == r0, "R8 no memory access", rd_cnt - r0, 0);
    boot_mode = 1;
    run(32'h12345678, 2'd2, 1);
    check(r_paddr == 36'hF_FFF4_5678 && r_rights == 3'b101, "R9 boot fetch rom", r_paddr, 36'hFFFF45678);
    run(32'h12345678, 2'd0, 1);
    check(r_paddr == 36'h012345678 && r_rights == 3'b111, "R9 boot load passes", r_paddr, 36'h012345678);
    boot_mode = 0;
  endtask

  task automatic t_busy_stall;
    int d0, n;
    stall = 1;
    @(negedge clk);
    d0 = done_cnt;
    req_vaddr = VA_C; req_kind = 0; req_bypass = 0; req_valid = 1;
    @(negedge clk);
    req_vaddr = VA_B;
    for (int i = 0; i < 3; i++) begin
      check(busy, "R10 busy during walk", busy, 1);
      @(negedge clk);
    end
    req_valid = 0;
    n = 0;
    while (!done && n < 500) begin @(negedge clk); n++; end
    check(done && paddr == 36'h721234, "R10 stalled walk result", paddr, 36'h721234);
    repeat (6) @(negedge clk);
    check(done_cnt - d0 == 1 && !busy, "R10 busy request ignored", done_cnt - d0, 1);
    stall = 0;
  endtask

  initial begin
    mem[36'h100C] = 32'h201;
    mem[36'h2028] = 32'h301;
    mem[36'h3014] = 32'h401;
    mem[36'h401C] = mk_pte(24'h12345, 0, 0, 3'd3);
    mem[36'h4024] = 32'h801;
    mem[36'h4028] = mk_pte(24'h0AAAA, 0, 0, 3'd1);
    errmap[36'h4020] = 1;
    mem[36'h202C] = mk_pte(24'h00500, 1, 1, 3'd3);
    mem[36'h2030] = 32'h501;
    mem[36'h5024] = mk_pte(24'h00700, 1, 1, 3'd3);
    mem[36'h2034] = 32'h601;
    mem[36'h2038] = 32'h3;
    mem[36'h1010] = 32'h2;
    errmap[36'h1018] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_walk_4k();
    t_wb_rules();
    t_large_pages();
    t_invalid();
    t_xlate_err();
    t_perm();
    t_bypass();
    t_busy_stall();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule